// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a DDR3-style command bus and runs from one single-ended clock. On each rising edge it samples clock enable, chip select, the three command strobes, the bank address, the address bus and the termination request. It decodes the command that was entered. For every bank it keeps a flag that says whether a row is open, and it stores the row that was opened. It also follows the low-power state of the device and keeps the few mode-register bits that choose between the data-mask and termination-strobe pin function and that gate on-die termination.

Every output is registered, so each one reflects the command sampled on the previous edge. The outputs are:
- the decoded command code;
- auto-precharge and burst-chop flags for accepted reads and writes, together with the open row that the access targets;
- a one-cycle pulse for a bank-protocol violation;
- a one-cycle pulse for an illegal drop of clock enable during an access.

The data path, delay-locked loop, impedance calibration and analog timing are out of scope.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: `cmd_o` gives the executed command as {RAS#,CAS#,WE#}: 0 mode-register set, 1 refresh, 2 precharge, 3 activate, 4 write, 5 read, 6 ZQ calibrate (flag only), 7 no-operation. A cycle with chip select high reports 7, whatever the three strobes are.
- R2: An activate to a closed bank sets that bank's bit in `bank_open_o` and stores the address as its open row. An accepted read or write reports that stored row on `access_row_o`.
- R3: A precharge with address bit 10 low closes only the bank on `ba`. With address bit 10 high it closes every bank.
- R4: An accepted read or write with address bit 10 high pulses `auto_pre_o`. The target bank is reported closed from the same cycle as the pulse.
- R5: An accepted read or write with address bit 12 low pulses `chop_o`. With bit 12 high, `chop_o` stays low.
- R6: An activate to an open bank, or a read or write to a closed bank, pulses `proto_err_o` for one cycle and leaves every bank's state unchanged.
- R7: `pwr_state_o` encodes 0 active, 1 precharge power-down, 2 active power-down, 3 self-refresh. Clock enable sampled low in the active state enters state 1 when all banks are closed and state 2 otherwise. While clock enable stays low, commands are not executed (`cmd_o` = 7). Clock enable sampled high in any low-power state returns to state 0.
- R8: A refresh sampled together with clock enable low in the active state enters self-refresh (state 3) and reports `cmd_o` = 1.
- R9: Clock enable sampled low in the active state pulses `cke_err_o` in two cases: in the same cycle as a read or write, or within ACCESS_CYC sampled edges after an accepted read or write. A read or write sampled with clock enable low is not executed.
- R10: A mode-register set with `ba[1:0]` = 1 copies address bit 11 to `tdqs_en_o`.
- R11: `odt_en_o` follows `odt_in` one cycle later, but only while termination is enabled. Termination is disabled when the nominal termination field (address bits 9, 6 and 2 of register 1) and the write termination field (address bits 10:9 of register 2) are both zero. While it is disabled, `odt_in` is ignored and `odt_en_o` stays 0.
- R12: `rst_n` low closes every bank at once without waiting for a clock edge. It also clears the mode bits and all pulses, sets `cmd_o` to 7 and sets the power state to active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W (3) | Bank address; mode-register select during MRS |
| addr | input | ADDR_W (15) | Row, column or op-code |
| odt_in | input | 1 | Termination request |
| cmd_o | output | 3 | Executed command code |
| auto_pre_o | output | 1 | Auto-precharge flag of accepted access |
| chop_o | output | 1 | Burst-chop flag of accepted access |
| access_row_o | output | ADDR_W (15) | Open row of the accessed bank |
| proto_err_o | output | 1 | Bank-protocol violation pulse |
| cke_err_o | output | 1 | Illegal clock-enable drop pulse |
| bank_open_o | output | NUM_BANKS (8) | Per-bank open flag |
| pwr_state_o | output | 2 | Power state |
| tdqs_en_o | output | 1 | Termination-strobe function selected |
| odt_en_o | output | 1 | Effective termination enable |

## Verification
The bench builds the block with its default values: eight banks, a 15-bit address and a four-edge access window. With eight banks, a precharge-all can be shown to clear a mix of open banks while a single-bank precharge leaves the rest alone. With the short window, the last illegal clock-enable cycle and the first legal one sit only a few cycles after a read, so both sides of that boundary are checked directly.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int NUM_BANKS  = 8,
  parameter int ADDR_W     = 15,
  parameter int ACCESS_CYC = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cke,
  input  logic                         cs_n,
  input  logic                         ras_n,
  input  logic                         cas_n,
  input  logic                         we_n,
  input  logic [$clog2(NUM_BANKS)-1:0] ba,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         odt_in,
  output logic [2:0]                   cmd_o,
  output logic                         auto_pre_o,
  output logic                         chop_o,
  output logic [ADDR_W-1:0]            access_row_o,
  output logic                         proto_err_o,
  output logic                         cke_err_o,
  output logic [NUM_BANKS-1:0]         bank_open_o,
  output logic [1:0]                   pwr_state_o,
  output logic                         tdqs_en_o,
  output logic                         odt_en_o
);
  localparam int CNT_W = $clog2(ACCESS_CYC + 1);

  localparam logic [2:0] C_MRS = 3'd0, C_REF = 3'd1, C_PRE = 3'd2, C_ACT = 3'd3,
                         C_WR  = 3'd4, C_RD  = 3'd5, C_NOP = 3'd7;
  localparam logic [1:0] P_ACT = 2'd0, P_PPD = 2'd1, P_APD = 2'd2, P_SR = 2'd3;

  logic [ADDR_W-1:0] rows [NUM_BANKS];
  logic [CNT_W-1:0]  busy_q;
  logic [2:0]        mr1_rtt;
  logic [1:0]        mr2_rtt;

  wire [2:0] op       = cs_n ? C_NOP : {ras_n, cas_n, we_n};
  wire       awake    = pwr_state_o == P_ACT;
  wire [2:0] exec     = (cke && awake) ? op : C_NOP;
  wire       tgt_open = bank_open_o[ba];
  wire       is_acc   = exec == C_RD || exec == C_WR;
  wire       acc_ok   = is_acc && tgt_open;
  wire       bad_cmd  = (is_acc && !tgt_open) || (exec == C_ACT && tgt_open);
  wire       drop     = awake && !cke;
  wire       enter_sr = drop && op == C_REF;
  wire       bad_drop = drop && (busy_q != '0 || op == C_RD || op == C_WR);
  wire       rtt_on   = (mr1_rtt != '0) || (mr2_rtt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o        <= C_NOP;
      auto_pre_o   <= 1'b0;
      chop_o       <= 1'b0;
      access_row_o <= '0;
      proto_err_o  <= 1'b0;
      cke_err_o    <= 1'b0;
      bank_open_o  <= '0;
      pwr_state_o  <= P_ACT;
      tdqs_en_o    <= 1'b0;
      odt_en_o     <= 1'b0;
      busy_q       <= '0;
      mr1_rtt      <= '0;
      mr2_rtt      <= '0;
      for (int i = 0; i < NUM_BANKS; i++) rows[i] <= '0;
    end else begin
      cmd_o       <= enter_sr ? C_REF : exec;
      auto_pre_o  <= acc_ok && addr[10];
      chop_o      <= acc_ok && !addr[12];
      proto_err_o <= bad_cmd;
      cke_err_o   <= bad_drop;
      odt_en_o    <= odt_in && rtt_on;

      if (acc_ok) begin
        access_row_o <= rows[ba];
        busy_q       <= CNT_W'(ACCESS_CYC);
      end else if (busy_q != '0) begin
        busy_q <= busy_q - 1'b1;
      end

      case (exec)
        C_ACT: if (!tgt_open) begin
          bank_open_o[ba] <= 1'b1;
          rows[ba]        <= addr;
        end
        C_PRE: if (addr[10]) bank_open_o <= '0;
               else          bank_open_o[ba] <= 1'b0;
        C_RD, C_WR: if (acc_ok && addr[10]) bank_open_o[ba] <= 1'b0;
        C_MRS: begin
          if (ba[1:0] == 2'd1) begin
            tdqs_en_o <= addr[11];
            mr1_rtt   <= {addr[9], addr[6], addr[2]};
          end
          if (ba[1:0] == 2'd2) mr2_rtt <= addr[10:9];
        end
        default: ;
      endcase

      case (pwr_state_o)
        P_ACT: if (!cke) pwr_state_o <= enter_sr ? P_SR :
                                        (bank_open_o != '0) ? P_APD : P_PPD;
        default: if (cke) pwr_state_o <= P_ACT;
      endcase
    end
  end
endmodule

module sdram_cmd_tracker_chk #(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [ADDR_W-1:0]    addr,
  input logic                 odt_in,
  input logic [2:0]           cmd_o,
  input logic                 proto_err_o,
  input logic                 cke_err_o,
  input logic [NUM_BANKS-1:0] bank_open_o,
  input logic [1:0]           pwr_state_o,
  input logic                 odt_en_o
);
  logic pv;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;

  // R1
  deselect_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> cmd_o == 3'd7);

  // R3
  precharge_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && pwr_state_o == 2'd0 && !cs_n && !ras_n && cas_n && !we_n && addr[10])
      |=> bank_open_o == '0);

  // R6
  proto_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && proto_err_o) |-> $stable(bank_open_o));

  // R7
  lowpower_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o != 2'd0) |=> cmd_o == 3'd7);

  // R8
  self_refresh_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 2'd3 && cke) |=> pwr_state_o == 2'd0);

  // R9
  cke_err_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke_err_o |-> pwr_state_o != 2'd0);

  // R11
  odt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && odt_en_o) |-> $past(odt_in));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .addr(addr), .odt_in(odt_in), .cmd_o(cmd_o), .proto_err_o(proto_err_o),
  .cke_err_o(cke_err_o), .bank_open_o(bank_open_o), .pwr_state_o(pwr_state_o),
  .odt_en_o(odt_en_o)
);

// File: tb/test_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module test_sdram_cmd_tracker;
  localparam logic [3:0] K_MRS = 4'b0000, K_REF = 4'b0001, K_PRE = 4'b0010, K_ACT = 4'b0011,
                         K_WR  = 4'b0100, K_RD  = 4'b0101, K_ZQ  = 4'b0110, K_NOP = 4'b0111,
                         K_DES = 4'b1000;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0]  ba = '0;
  logic [14:0] addr = '0;
  logic        odt_in = 1'b0;
  logic [2:0]  cmd_o;
  logic        auto_pre_o, chop_o, proto_err_o, cke_err_o, tdqs_en_o, odt_en_o;
  logic [14:0] access_row_o;
  logic [7:0]  bank_open_o;
  logic [1:0]  pwr_state_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker i_sdram_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .odt_in(odt_in), .cmd_o(cmd_o), .auto_pre_o(auto_pre_o),
    .chop_o(chop_o), .access_row_o(access_row_o), .proto_err_o(proto_err_o),
    .cke_err_o(cke_err_o), .bank_open_o(bank_open_o), .pwr_state_o(pwr_state_o),
    .tdqs_en_o(tdqs_en_o), .odt_en_o(odt_en_o));

  // {cke, code, ba, addr, exp cmd, exp proto_err, exp bank_open, exp pwr}
  localparam logic [36:0] VEC [19] = '{
    {1'b1, K_NOP, 3'd0, 15'h0000, 3'd7, 1'b0, 8'h00, 2'd0},
    {1'b1, K_ACT, 3'd2, 15'h1234, 3'd3, 1'b0, 8'h04, 2'd0},
    {1'b1, K_ACT, 3'd2, 15'h0001, 3'd3, 1'b1, 8'h04, 2'd0},
    {1'b1, K_RD,  3'd5, 15'h0000, 3'd5, 1'b1, 8'h04, 2'd0},
    {1'b1, K_DES, 3'd5, 15'h0000, 3'd7, 1'b0, 8'h04, 2'd0},
    {1'b1, K_ACT, 3'd5, 15'h7FFF, 3'd3, 1'b0, 8'h24, 2'd0},
    {1'b1, K_PRE, 3'd2, 15'h0000, 3'd2, 1'b0, 8'h20, 2'd0},
    {1'b1, K_ACT, 3'd0, 15'h0001, 3'd3, 1'b0, 8'h21, 2'd0},
    {1'b1, K_PRE, 3'd3, 15'h0400, 3'd2, 1'b0, 8'h00, 2'd0},
    {1'b0, K_NOP, 3'd0, 15'h0000, 3'd7, 1'b0, 8'h00, 2'd1},
    {1'b0, K_ACT, 3'd1, 15'h0000, 3'd7, 1'b0, 8'h00, 2'd1},
    {1'b1, K_NOP, 3'd0, 15'h0000, 3'd7, 1'b0, 8'h00, 2'd0},
    {1'b1, K_ACT, 3'd3, 15'h0033, 3'd3, 1'b0, 8'h08, 2'd0},
    {1'b0, K_NOP, 3'd0, 15'h0000, 3'd7, 1'b0, 8'h08, 2'd2},
    {1'b1, K_NOP, 3'd0, 15'h0000, 3'd7, 1'b0, 8'h08, 2'd0},
    {1'b1, K_PRE, 3'd3, 15'h0000, 3'd2, 1'b0, 8'h00, 2'd0},
    {1'b0, K_REF, 3'd0, 15'h0000, 3'd1, 1'b0, 8'h00, 2'd3},  // R8 self-refresh entry
    {1'b0, K_NOP, 3'd0, 15'h0000, 3'd7, 1'b0, 8'h00, 2'd3},
    {1'b1, K_NOP, 3'd0, 15'h0000, 3'd7, 1'b0, 8'h00, 2'd0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic k, input logic [3:0] c, input logic [2:0] b, input logic [14:0] a);
    cke = k; {cs_n, ras_n, cas_n, we_n} = c; ba = b; addr = a;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "cmd", cmd_o, 7);
    chk("R12", "open", bank_open_o, 0);
    chk("R12", "pwr", pwr_state_o, 0);
    chk("R12", "tdqs", tdqs_en_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 19; i++) begin
      logic [36:0] v;
      v = VEC[i];
      step(v[36], v[35:32], v[31:29], v[28:14]);
      chk("R1", "cmd", cmd_o, v[13:11]);
      chk("R6", "proto_err", proto_err_o, v[10]);
      chk("R3", "bank_open", bank_open_o, v[9:2]);
      chk("R7", "pwr_state", pwr_state_o, v[1:0]);
    end

    // R4 R5 R2: write with auto-precharge and chop
    step(1, K_ACT, 4, 15'h0ABC);
    step(1, K_WR, 4, 15'h0400);
    chk("R4", "auto_pre", auto_pre_o, 1);
    chk("R5", "chop", chop_o, 1);
    chk("R2", "row", access_row_o, 15'h0ABC);
    chk("R4", "open", bank_open_o, 0);

    step(1, K_ACT, 6, 15'h5555);
    step(1, K_RD, 6, 15'h1000);
    chk("R4", "auto_pre", auto_pre_o, 0);
    chk("R5", "chop", chop_o, 0);
    chk("R2", "row", access_row_o, 15'h5555);
    chk("R2", "open", bank_open_o, 8'h40);

    // R9: drop right after read
    step(0, K_NOP, 0, 0);
    chk("R9", "cke_err", cke_err_o, 1);
    chk("R7", "pwr", pwr_state_o, 2);
    step(1, K_NOP, 0, 0);
    chk("R9", "cke_err", cke_err_o, 0);
    step(1, K_NOP, 0, 0);
    step(1, K_NOP, 0, 0);
    step(0, K_NOP, 0, 0);
    chk("R9", "cke_err window end", cke_err_o, 0);
    chk("R7", "pwr", pwr_state_o, 2);
    step(1, K_NOP, 0, 0);
    step(0, K_RD, 6, 0);
    chk("R9", "cke_err same cycle", cke_err_o, 1);
    chk("R9", "cmd not run", cmd_o, 7);
    step(1, K_NOP, 0, 0);
    step(1, K_PRE, 0, 15'h0400);
    chk("R3", "open", bank_open_o, 0);

    // R10 R11 mode bits
    step(1, K_MRS, 1, 15'h0800);
    chk("R10", "tdqs", tdqs_en_o, 1);
    odt_in = 1'b1;
    step(1, K_NOP, 0, 0);
    chk("R11", "odt ignored", odt_en_o, 0);
    step(1, K_MRS, 2, 15'h0200);
    step(1, K_NOP, 0, 0);
    chk("R11", "odt wr term", odt_en_o, 1);
    step(1, K_MRS, 1, 15'h0004);
    chk("R10", "tdqs", tdqs_en_o, 0);
    step(1, K_MRS, 2, 15'h0000);
    step(1, K_NOP, 0, 0);
    chk("R11", "odt nom term", odt_en_o, 1);
    step(1, K_MRS, 1, 15'h0000);
    step(1, K_NOP, 0, 0);
    chk("R11", "odt off", odt_en_o, 0);
    odt_in = 1'b0;

    step(1, K_ZQ, 0, 0);
    chk("R1", "zq", cmd_o, 6);

    // R12 asynchronous reset
    step(1, K_MRS, 1, 15'h0800);
    step(1, K_ACT, 7, 15'h0001);
    chk("R2", "open", bank_open_o, 8'h80);
    #1 rst_n = 1'b0;
    #1;
    chk("R12", "open", bank_open_o, 0);
    chk("R12", "tdqs", tdqs_en_o, 0);
    chk("R12", "cmd", cmd_o, 7);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule